// File: doc/BRIEF.md
# Shader Code Upload Controller with Vertex-to-Geometry Mirroring

This block loads shader microcode and operand-pattern words into four local memories that belong to two shader units: a vertex unit and a geometry unit. Each unit has a program memory and a swizzle-pattern memory. A host writes 32-bit words over a simple address, data and write-strobe bus. Each memory is fed by a window of eight neighbouring data addresses that all behave the same, so a host can burst words to consecutive addresses. Each memory also has its own position register, which the host can load directly.

Every accepted word goes to the memory at that stream's current position, and the position then moves on by one. A word that arrives when the position is already past the end of the memory is dropped, and a one-cycle error pulse is raised. A single configuration bit selects whether the geometry unit is configured exclusively. While that bit is clear, every accepted vertex-unit word is also copied into the matching geometry memory at the same index. The geometry unit's own position registers do not move when this happens.

Top module: `shader_upload_ctrl`

## Requirements
- R1: After reset, all four position registers are 0 and the exclusive bit is 0, so mirroring is active and a first vertex swizzle word lands at index 0 of both swizzle memories.
- R2: A write to any address in a stream's eight-address data window has the same effect. The windows are: geometry program 0x29C to 0x2A3, geometry swizzle 0x2A6 to 0x2AD.
- R3: The vertex program data window is 0x2CC to 0x2D3 and the vertex swizzle data window is 0x2D6 to 0x2DD.
- R4: An accepted data word is stored at the stream's current position, and that position then increases by one.
- R5: Memory depths are GS_PROG_DEPTH (geometry program), VS_PROG_DEPTH (vertex program) and SWZ_DEPTH (each swizzle memory). A data write whose position is at or above the depth is dropped: no memory changes and the position stays the same.
- R6: err_o is high for exactly the one cycle after the clock edge that dropped a write, and low otherwise.
- R7: Each position register is loaded by a write to the address just below its data window (0x29B, 0x2A5, 0x2CB, 0x2D5) and takes the low OFS_W bits of the data.
- R8: The exclusive bit is bit 0 of the configuration register at 0x244. While it is 0, each accepted vertex program or vertex swizzle word is also written to the geometry memory of the same kind at the same index.
- R9: A mirrored write leaves the geometry position registers unchanged.
- R10: While the exclusive bit is 1, vertex writes do not change the geometry memories.
- R11: Each memory has a read port whose data shows the word at the read address one clock after that address is sampled. A write to an address outside all windows, position registers and the configuration register has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write strobe |
| wr_addr_i | input | 10 | Bus word address |
| wr_data_i | input | 32 | Bus write data |
| err_o | output | 1 | Pulse: a data write was dropped as out of range |
| gp_raddr_i | input | clog2(GS_PROG_DEPTH) | Geometry program read address |
| gp_rdata_o | output | 32 | Geometry program read data |
| gs_raddr_i | input | clog2(SWZ_DEPTH) | Geometry swizzle read address |
| gs_rdata_o | output | 32 | Geometry swizzle read data |
| vp_raddr_i | input | clog2(VS_PROG_DEPTH) | Vertex program read address |
| vp_rdata_o | output | 32 | Vertex program read data |
| vs_raddr_i | input | clog2(SWZ_DEPTH) | Vertex swizzle read address |
| vs_rdata_o | output | 32 | Vertex swizzle read data |

## Verification
The assertions assume the bus carries at most one write per cycle, so at most one stream accepts a word in any cycle. They also assume VS_PROG_DEPTH is no larger than GS_PROG_DEPTH, so that a mirrored index always fits in the geometry program memory. The bench uses a single-strobe write task that holds the strobe for exactly one cycle, and a shrunken configuration (64, 32 and 16 words) in which the vertex depth stays below the geometry depth. Each memory is filled completely through the rotating aliases and then pushed one word past its end.

// File: rtl/shu_pkg.sv
package shu_pkg;
  localparam int ADDR_W  = 10;
  localparam int NSTREAM = 4;
  // stream order: 0 geo program, 1 geo swizzle, 2 vtx program, 3 vtx swizzle
  localparam logic [ADDR_W-1:0] DATA_BASE [NSTREAM] = '{10'h29C, 10'h2A6, 10'h2CC, 10'h2D6};
  localparam logic [ADDR_W-1:0] CFG_ADDR  = 10'h244;
  localparam int ALIAS_N = 8;
endpackage

// File: rtl/shu_decode.sv
module shu_decode
  import shu_pkg::*;
(
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output logic [NSTREAM-1:0] data_hit_o,
  output logic [NSTREAM-1:0] ofs_hit_o,
  output logic              cfg_hit_o
);
  for (genvar i = 0; i < NSTREAM; i++) begin : g_dec
    assign data_hit_o[i] = wr_en_i && (wr_addr_i >= DATA_BASE[i])
                           && (wr_addr_i <= DATA_BASE[i] + ADDR_W'(ALIAS_N - 1));
    assign ofs_hit_o[i]  = wr_en_i && (wr_addr_i == DATA_BASE[i] - ADDR_W'(1));
  end
  assign cfg_hit_o = wr_en_i && (wr_addr_i == CFG_ADDR);
endmodule

// File: rtl/shu_stream.sv
module shu_stream #(
  parameter int DEPTH = 512,
  parameter int OFS_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             data_wr_i,
  input  logic             ofs_wr_i,
  input  logic [OFS_W-1:0] ofs_data_i,
  output logic [OFS_W-1:0] ofs_o,
  output logic             accept_o,
  output logic             discard_o
);
  logic [OFS_W-1:0] ofs_q;
  logic             in_range;

  assign in_range  = {1'b0, ofs_q} < (OFS_W+1)'(DEPTH);
  assign accept_o  = data_wr_i && in_range;
  assign discard_o = data_wr_i && !in_range;
  assign ofs_o     = ofs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ofs_q <= '0;
    else if (ofs_wr_i) ofs_q <= ofs_data_i;
    else if (accept_o) ofs_q <= ofs_q + OFS_W'(1);
  end

  AST_OFS_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr_i && in_range |=> ofs_q == $past(ofs_q) + OFS_W'(1)); // R4
  AST_DROP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr_i && !in_range |=> $stable(ofs_q)); // R5
  AST_OFS_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ofs_wr_i |=> ofs_q == $past(ofs_data_i)); // R7
  AST_ONE_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ofs_wr_i && data_wr_i)); // R2
endmodule

// File: rtl/shu_mem.sv
module shu_mem #(
  parameter int DEPTH = 512,
  parameter int DW    = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/shader_upload_ctrl.sv
module shader_upload_ctrl
  import shu_pkg::*;
#(
  parameter int GS_PROG_DEPTH = 4096,
  parameter int VS_PROG_DEPTH = 512,
  parameter int SWZ_DEPTH     = 128,
  parameter int OFS_W         = 16,
  localparam int GP_AW = $clog2(GS_PROG_DEPTH),
  localparam int VP_AW = $clog2(VS_PROG_DEPTH),
  localparam int SW_AW = $clog2(SWZ_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [31:0]       wr_data_i,
  output logic              err_o,
  input  logic [GP_AW-1:0]  gp_raddr_i,
  output logic [31:0]       gp_rdata_o,
  input  logic [SW_AW-1:0]  gs_raddr_i,
  output logic [31:0]       gs_rdata_o,
  input  logic [VP_AW-1:0]  vp_raddr_i,
  output logic [31:0]       vp_rdata_o,
  input  logic [SW_AW-1:0]  vs_raddr_i,
  output logic [31:0]       vs_rdata_o
);
  logic [NSTREAM-1:0] data_hit, ofs_hit, acc, dis;
  logic               cfg_hit;
  logic               excl_q, err_q;
  logic [OFS_W-1:0]   ofs_a [NSTREAM];
  logic               gp_we, gs_we;
  logic [GP_AW-1:0]   gp_waddr;
  logic [SW_AW-1:0]   gs_waddr;

  shu_decode u_dec (
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .data_hit_o(data_hit),
    .ofs_hit_o (ofs_hit),
    .cfg_hit_o (cfg_hit)
  );

  for (genvar i = 0; i < NSTREAM; i++) begin : g_str
    localparam int D = (i == 0) ? GS_PROG_DEPTH : (i == 2) ? VS_PROG_DEPTH : SWZ_DEPTH;
    shu_stream #(.DEPTH(D), .OFS_W(OFS_W)) u_str (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .data_wr_i (data_hit[i]),
      .ofs_wr_i  (ofs_hit[i]),
      .ofs_data_i(wr_data_i[OFS_W-1:0]),
      .ofs_o     (ofs_a[i]),
      .accept_o  (acc[i]),
      .discard_o (dis[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      excl_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (cfg_hit) excl_q <= wr_data_i[0];
      err_q <= |dis;
    end
  end
  assign err_o = err_q;

  // geometry memories take their own stream or a mirrored vertex word
  assign gp_we    = acc[0] || (acc[2] && !excl_q);
  assign gp_waddr = acc[0] ? ofs_a[0][GP_AW-1:0] : GP_AW'(ofs_a[2][VP_AW-1:0]);
  assign gs_we    = acc[1] || (acc[3] && !excl_q);
  assign gs_waddr = acc[1] ? ofs_a[1][SW_AW-1:0] : ofs_a[3][SW_AW-1:0];

  shu_mem #(.DEPTH(GS_PROG_DEPTH), .AW(GP_AW)) u_gp_mem (
    .clk_i(clk_i), .we_i(gp_we), .waddr_i(gp_waddr), .wdata_i(wr_data_i),
    .raddr_i(gp_raddr_i), .rdata_o(gp_rdata_o));
  shu_mem #(.DEPTH(SWZ_DEPTH), .AW(SW_AW)) u_gs_mem (
    .clk_i(clk_i), .we_i(gs_we), .waddr_i(gs_waddr), .wdata_i(wr_data_i),
    .raddr_i(gs_raddr_i), .rdata_o(gs_rdata_o));
  shu_mem #(.DEPTH(VS_PROG_DEPTH), .AW(VP_AW)) u_vp_mem (
    .clk_i(clk_i), .we_i(acc[2]), .waddr_i(ofs_a[2][VP_AW-1:0]), .wdata_i(wr_data_i),
    .raddr_i(vp_raddr_i), .rdata_o(vp_rdata_o));
  shu_mem #(.DEPTH(SWZ_DEPTH), .AW(SW_AW)) u_vs_mem (
    .clk_i(clk_i), .we_i(acc[3]), .waddr_i(ofs_a[3][SW_AW-1:0]), .wdata_i(wr_data_i),
    .raddr_i(vs_raddr_i), .rdata_o(vs_rdata_o));

  AST_ONE_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(acc)); // R2
  AST_MIRROR_PROG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc[2] && !excl_q |-> gp_we && (gp_waddr == GP_AW'(ofs_a[2][VP_AW-1:0]))); // R8
  AST_MIRROR_SWZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc[3] && !excl_q |-> gs_we && (gs_waddr == ofs_a[3][SW_AW-1:0])); // R8
  AST_GEO_OFS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc[2] || acc[3]) |=> $stable(ofs_a[0]) && $stable(ofs_a[1])); // R9
  AST_EXCL_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    excl_q && !data_hit[0] && !data_hit[1] |-> !gp_we && !gs_we); // R10
  AST_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(|dis)); // R6
endmodule

// File: tb/sim_shader_upload_ctrl.sv
`timescale 1ns/1ps
module sim_shader_upload_ctrl;
  localparam int GPD = 64, VPD = 32, SWD = 16;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [9:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        err;
  logic [5:0]  gp_ra = '0;
  logic [3:0]  gs_ra = '0, vs_ra = '0;
  logic [4:0]  vp_ra = '0;
  logic [31:0] gp_rd, gs_rd, vp_rd, vs_rd;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  shader_upload_ctrl #(.GS_PROG_DEPTH(GPD), .VS_PROG_DEPTH(VPD), .SWZ_DEPTH(SWD)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .err_o(err), .gp_raddr_i(gp_ra), .gp_rdata_o(gp_rd), .gs_raddr_i(gs_ra), .gs_rdata_o(gs_rd),
    .vp_raddr_i(vp_ra), .vp_rdata_o(vp_rd), .vs_raddr_i(vs_ra), .vs_rdata_o(vs_rd));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [9:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // which: 0 gp, 1 gs, 2 vp, 3 vs
  task automatic rd(int which, int idx, output logic [31:0] d);
    @(negedge clk);
    case (which)
      0: gp_ra = 6'(idx);
      1: gs_ra = 4'(idx);
      2: vp_ra = 5'(idx);
      default: vs_ra = 4'(idx);
    endcase
    @(negedge clk);
    case (which)
      0: d = gp_rd;
      1: d = gs_rd;
      2: d = vp_rd;
      default: d = vs_rd;
    endcase
  endtask

  task automatic rd_chk(string req, int which, int idx, logic [31:0] exp);
    logic [31:0] d;
    rd(which, idx, d);
    check(req, d, exp);
  endtask

  task automatic err_pulse(string req);
    check(req, {31'd0, err}, 32'd1);
    @(negedge clk);
    check(req, {31'd0, err}, 32'd0);
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 err idle", {31'd0, err}, 32'd0);
    // R1: mirroring active from reset, position 0
    bus_wr(10'h2D6, 32'h5A5A_0001);
    rd_chk("R1 vs[0]", 3, 0, 32'h5A5A_0001);
    rd_chk("R1 gs[0] mirror", 1, 0, 32'h5A5A_0001);

    bus_wr(10'h244, 32'h1); // exclusive on
    // R2: geometry program fill through rotating aliases
    for (int i = 0; i < GPD; i++) bus_wr(10'h29C + 10'(i % 8), 32'h1000_0000 + 32'(i * 7));
    check("R4 no err in range", {31'd0, err}, 32'd0);
    bus_wr(10'h2A3, 32'hDEAD_BEEF);
    err_pulse("R6 gp overflow");
    for (int i = 0; i < GPD; i++) rd_chk("R2 gp", 0, i, 32'h1000_0000 + 32'(i * 7));
    // R2: geometry swizzle
    for (int i = 0; i < SWD; i++) bus_wr(10'h2A6 + 10'(i % 8), 32'h2000_0000 + 32'(i * 11));
    bus_wr(10'h2A6, 32'hDEAD_0001);
    err_pulse("R5 gs overflow");
    for (int i = 0; i < SWD; i++) rd_chk("R4 gs", 1, i, 32'h2000_0000 + 32'(i * 11));
    // R3: vertex program, exclusive on
    for (int i = 0; i < VPD; i++) bus_wr(10'h2CC + 10'(i % 8), 32'h3000_0000 + 32'(i * 13));
    bus_wr(10'h2D3, 32'hDEAD_0002);
    err_pulse("R6 vp overflow");
    for (int i = 0; i < VPD; i++) rd_chk("R3 vp", 2, i, 32'h3000_0000 + 32'(i * 13));
    for (int i = 0; i < VPD; i++) rd_chk("R10 gp untouched", 0, i, 32'h1000_0000 + 32'(i * 7));
    // R3: vertex swizzle, position reloaded to 0
    bus_wr(10'h2D5, 32'h0);
    for (int i = 0; i < SWD; i++) bus_wr(10'h2D6 + 10'(i % 8), 32'h4000_0000 + 32'(i * 5));
    bus_wr(10'h2DD, 32'hDEAD_0003);
    err_pulse("R5 vs overflow");
    for (int i = 0; i < SWD; i++) rd_chk("R3 vs", 3, i, 32'h4000_0000 + 32'(i * 5));
    for (int i = 0; i < SWD; i++) rd_chk("R10 gs untouched", 1, i, 32'h2000_0000 + 32'(i * 11));

    // R8: mirroring back on
    bus_wr(10'h244, 32'h0);
    bus_wr(10'h29B, 32'd40);
    bus_wr(10'h2CB, 32'd0);
    for (int i = 0; i < VPD; i++) bus_wr(10'h2CC + 10'(i % 8), 32'h5000_0000 + 32'(i * 17));
    for (int i = 0; i < VPD; i++) begin
      rd_chk("R8 vp", 2, i, 32'h5000_0000 + 32'(i * 17));
      rd_chk("R8 gp mirror", 0, i, 32'h5000_0000 + 32'(i * 17));
    end
    // R9: geometry position still 40
    bus_wr(10'h2A0, 32'h6000_0040);
    rd_chk("R9 gp[40]", 0, 40, 32'h6000_0040);
    rd_chk("R9 gp[41]", 0, 41, 32'h1000_0000 + 32'(41 * 7));
    // R7: only low OFS_W bits load
    bus_wr(10'h2A5, 32'hFFFF_0003);
    bus_wr(10'h2AA, 32'h7000_0003);
    rd_chk("R7 gs[3]", 1, 3, 32'h7000_0003);
    bus_wr(10'h2D5, 32'd5);
    for (int i = 0; i < 3; i++) bus_wr(10'h2D8 + 10'(i), 32'h8000_0000 + 32'(i));
    for (int i = 0; i < 3; i++) begin
      rd_chk("R7 vs", 3, 5 + i, 32'h8000_0000 + 32'(i));
      rd_chk("R8 gs mirror", 1, 5 + i, 32'h8000_0000 + 32'(i));
    end
    rd_chk("R8 gs[4] kept", 1, 4, 32'h2000_0000 + 32'(4 * 11));
    // R5: loaded position past the end
    bus_wr(10'h2CB, 32'd100);
    bus_wr(10'h2CC, 32'hDEAD_0004);
    err_pulse("R5 vp high pos");
    rd_chk("R5 gp[0] kept", 0, 0, 32'h5000_0000);
    // R11: unmapped address is inert; gs position still 4
    bus_wr(10'h2A4, 32'h9999_9999);
    check("R11 no err", {31'd0, err}, 32'd0);
    bus_wr(10'h2A6, 32'hA000_0004);
    rd_chk("R11 gs[4]", 1, 4, 32'hA000_0004);
    rd_chk("R11 gs[5] kept", 1, 5, 32'h8000_0000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule